// File: doc/BRIEF.md
# Seconds Timekeeper with Match Alarms

The block keeps time as a running count of seconds. A one-cycle tick input, produced elsewhere once per second, advances a 32-bit up-counter and steps a companion 32-bit down-counter the other way. Software loads the two counters as complements, so either one can be read to get elapsed or remaining time. Two 32-bit compare registers are checked against the up-counter. A hit latches a sticky status flag, and that flag can raise an interrupt or drive a wake output.

Software reaches the block over a single-cycle register bus. Writes take effect at the clock edge, and read data is combinational from the address. A hold bit in the control register freezes both counters so that software can load them atomically. A counter-reset bit pins the counters at their origin. A 32-bit key register keeps its value through a counter reset. Software uses it to tell whether the block has already been set up.

Top module: `sec_timekeeper`

## Requirements
- R1: After the asynchronous reset, the up-counter reads 0, the down-counter reads 0xFFFFFFFF, and control, both compare registers, key and status read 0. Both compare registers then equal the up-counter, so status reads 3 after the first clock edge.
- R2: On a cycle with tick high, no counter load, no hold and no counter reset, the up-counter adds 1 and the down-counter subtracts 1. Both wrap modulo 2^32.
- R3: While control bit 6 (hold) is set, ticks leave both counters unchanged, but bus loads still take effect. Counting resumes once the bit is cleared.
- R4: While control bit 4 (counter reset) is set, the up-counter is forced to 0 and the down-counter to 0xFFFFFFFF. The key register is left unchanged.
- R5: A write to byte offset 0x00 loads the up-counter and a write to 0x04 loads the down-counter. A load to either counter overrides a tick in the same cycle.
- R6: Status bit k (k=0 for the compare register at 0x08, k=1 for the one at 0x0C) is set at every clock edge where the up-counter equals compare register k. It stays set until cleared.
- R7: Writing status (offset 0x14) clears each bit written as 1 and leaves each bit written as 0. A same-cycle set wins over the clear. After loading 0xFFFFFFFF into the compare register, the cleared flag stays clear.
- R8: irq_o is high when status bit 0 and control bit 0 are both set, or when status bit 1 and control bit 1 are both set.
- R9: wake_o is high when control bit 7 is set, or status bit 0 with control bit 2, or status bit 1 with control bit 3. Status bit 2 is set at every edge where wake_o is high, and it is sticky and write-one-to-clear.
- R10: The key register at offset 0x18 is a plain 32-bit read/write register that changes only when written.
- R11: Control reads back only bits 0-4, 6 and 7, with all other bits 0. Any address other than the seven word-aligned offsets 0x00-0x18 reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_i | input | 1 | One-cycle seconds tick |
| addr_i | input | 5 | Byte address of the register |
| we_i | input | 1 | Write strobe |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data for addr_i, combinational |
| irq_o | output | 1 | Interrupt, enabled match flags |
| wake_o | output | 1 | Wake output |

## Verification
The bench targets the edges around a match:
- A status clear written while the up-counter still equals the compare value must leave the flag set. A design that lets the clear win would drop a live alarm.
- A clear written after parking the compare register at all ones must stick. A design that keeps stale compare state would fire again.
- A write to status with zero bits must leave those flags alone.

It also checks the counter edges:
- The wrap from all ones to zero.
- Loads while held.
- A load racing a tick, where a wrong priority shows up as an off-by-one count.
- A counter reset, which must leave the key intact. A design that clears the key would make software think the block was never set up.

Random traffic keeps compare values near the running count so that matches, re-latching and irq/wake routing are exercised often.

// File: rtl/stk_pkg.sv
package stk_pkg;
  localparam int N_MATCH = 2;
  localparam int IDX_W   = 3;

  // word index = byte address >> 2
  typedef enum logic [IDX_W-1:0] {
    W_UP   = 3'd0,
    W_DN   = 3'd1,
    W_CMP0 = 3'd2,
    W_CMP1 = 3'd3,
    W_CTRL = 3'd4,
    W_STAT = 3'd5,
    W_KEY  = 3'd6
  } reg_idx_e;

  typedef struct packed {
    logic               wake_force;
    logic               hold;
    logic               srst;
    logic [N_MATCH-1:0] wake_en;
    logic [N_MATCH-1:0] irq_en;
  } ctrl_t;

  function automatic ctrl_t unpack_ctrl(input logic [7:0] raw);
    ctrl_t c;
    c.irq_en     = raw[1:0];
    c.wake_en    = raw[3:2];
    c.srst       = raw[4];
    c.hold       = raw[6];
    c.wake_force = raw[7];
    return c;
  endfunction

  function automatic logic [7:0] pack_ctrl(input ctrl_t c);
    return {c.wake_force, c.hold, 1'b0, c.srst, c.wake_en, c.irq_en};
  endfunction
endpackage

// File: rtl/stk_regs.sv
module stk_regs
  import stk_pkg::*;
#(
  parameter int DW = 32
) (
  input  logic                         clk_i,
  input  logic                         rst_ni,
  input  logic                         wr_i,
  input  logic [IDX_W-1:0]             idx_i,
  input  logic [DW-1:0]                wdata_i,
  output ctrl_t                        ctrl_o,
  output logic [N_MATCH-1:0][DW-1:0]   cmp_o,
  output logic [DW-1:0]                key_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                      ctrl_o <= '0;
    else if (wr_i && idx_i == W_CTRL) ctrl_o <= unpack_ctrl(wdata_i[7:0]);
  end

  for (genvar k = 0; k < N_MATCH; k++) begin : g_cmp
    localparam logic [IDX_W-1:0] SLOT = IDX_W'(int'(W_CMP0) + k);
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                    cmp_o[k] <= '0;
      else if (wr_i && idx_i == SLOT) cmp_o[k] <= wdata_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                     key_o <= '0;
    else if (wr_i && idx_i == W_KEY) key_o <= wdata_i;
  end

  // R10 / R4: key only moves on its own write
  a_r10_key_kept: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(wr_i && idx_i == W_KEY) |=> key_o == $past(key_o));

  a_r10_key_load: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && idx_i == W_KEY) |=> key_o == $past(wdata_i));
endmodule

// File: rtl/stk_counters.sv
module stk_counters #(
  parameter int DW = 32
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          tick_i,
  input  logic          hold_i,
  input  logic          srst_i,
  input  logic          ld_up_i,
  input  logic          ld_dn_i,
  input  logic [DW-1:0] wdata_i,
  output logic [DW-1:0] up_o,
  output logic [DW-1:0] dn_o
);
  localparam logic [DW-1:0] ONE = DW'(1);

  logic ld_any;
  assign ld_any = ld_up_i | ld_dn_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      up_o <= '0;
      dn_o <= '1;
    end else if (srst_i) begin
      up_o <= '0;
      dn_o <= '1;
    end else if (ld_any) begin
      // load beats tick for both counters
      if (ld_up_i) up_o <= wdata_i;
      if (ld_dn_i) dn_o <= wdata_i;
    end else if (tick_i && !hold_i) begin
      up_o <= up_o + ONE;
      dn_o <= dn_o - ONE;
    end
  end

  a_r2_tick_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_i && !hold_i && !srst_i && !ld_any)
      |=> (up_o == $past(up_o) + ONE) && (dn_o == $past(dn_o) - ONE));

  a_r3_hold_frozen: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hold_i && !srst_i && !ld_any) |=> $stable(up_o) && $stable(dn_o));

  a_r4_srst_origin: assert property (@(posedge clk_i) disable iff (!rst_ni)
    srst_i |=> (up_o == '0) && (dn_o == '1));

  a_r5_load_up: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ld_up_i && !srst_i) |=> up_o == $past(wdata_i));
endmodule

// File: rtl/stk_match.sv
module stk_match
  import stk_pkg::*;
#(
  parameter int DW = 32
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic [DW-1:0]              up_i,
  input  logic [N_MATCH-1:0][DW-1:0] cmp_i,
  input  ctrl_t                      ctrl_i,
  input  logic                       clr_i,
  input  logic [N_MATCH:0]           clr_bits_i,
  output logic [N_MATCH:0]           flags_o,
  output logic                       irq_o,
  output logic                       wake_o
);
  localparam int WK = N_MATCH;

  logic [N_MATCH:0] set_v;
  logic [N_MATCH:0] clr_v;

  assign clr_v = clr_i ? clr_bits_i : '0;

  for (genvar k = 0; k < N_MATCH; k++) begin : g_hit
    assign set_v[k] = (up_i == cmp_i[k]);

    a_r6_match_sets: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (up_i == cmp_i[k]) |=> flags_o[k]);

    a_r7_w1c_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (clr_i && clr_bits_i[k] && up_i != cmp_i[k]) |=> !flags_o[k]);

    a_r7_zero_keeps: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (flags_o[k] && !(clr_i && clr_bits_i[k])) |=> flags_o[k]);
  end

  assign wake_o    = ctrl_i.wake_force | (|(flags_o[N_MATCH-1:0] & ctrl_i.wake_en));
  assign set_v[WK] = wake_o;
  assign irq_o     = |(flags_o[N_MATCH-1:0] & ctrl_i.irq_en);

  // set has priority over a same-cycle clear
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) flags_o <= '0;
    else         flags_o <= set_v | (flags_o & ~clr_v);
  end

  a_r9_wake_latch: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wake_o |=> flags_o[WK]);

  a_r9_force_wake: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ctrl_i.wake_force |-> wake_o);
endmodule

// File: rtl/sec_timekeeper.sv
module sec_timekeeper
  import stk_pkg::*;
#(
  parameter int DW = 32,
  parameter int AW = 5
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          tick_i,
  input  logic [AW-1:0] addr_i,
  input  logic          we_i,
  input  logic [DW-1:0] wdata_i,
  output logic [DW-1:0] rdata_o,
  output logic          irq_o,
  output logic          wake_o
);
  logic [IDX_W-1:0]           idx;
  logic                       in_map;
  logic                       wr;
  ctrl_t                      ctrl;
  logic [N_MATCH-1:0][DW-1:0] cmp;
  logic [DW-1:0]              key;
  logic [DW-1:0]              up;
  logic [DW-1:0]              dn;
  logic [N_MATCH:0]           flags;

  assign idx    = addr_i[IDX_W+1:2];
  assign in_map = (addr_i[1:0] == 2'b00) && ((addr_i >> (IDX_W + 2)) == '0) && (idx <= W_KEY);
  assign wr     = we_i && in_map;

  stk_regs #(.DW(DW)) u_regs (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .wr_i    (wr),
    .idx_i   (idx),
    .wdata_i (wdata_i),
    .ctrl_o  (ctrl),
    .cmp_o   (cmp),
    .key_o   (key)
  );

  stk_counters #(.DW(DW)) u_cnt (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .tick_i  (tick_i),
    .hold_i  (ctrl.hold),
    .srst_i  (ctrl.srst),
    .ld_up_i (wr && idx == W_UP),
    .ld_dn_i (wr && idx == W_DN),
    .wdata_i (wdata_i),
    .up_o    (up),
    .dn_o    (dn)
  );

  stk_match #(.DW(DW)) u_match (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .up_i       (up),
    .cmp_i      (cmp),
    .ctrl_i     (ctrl),
    .clr_i      (wr && idx == W_STAT),
    .clr_bits_i (wdata_i[N_MATCH:0]),
    .flags_o    (flags),
    .irq_o      (irq_o),
    .wake_o     (wake_o)
  );

  always_comb begin
    rdata_o = '0;
    if (in_map) begin
      case (idx)
        W_UP:    rdata_o = up;
        W_DN:    rdata_o = dn;
        W_CTRL:  rdata_o = DW'(pack_ctrl(ctrl));
        W_STAT:  rdata_o = DW'(flags);
        W_KEY:   rdata_o = key;
        default: rdata_o = '0;
      endcase
      for (int k = 0; k < N_MATCH; k++)
        if (idx == IDX_W'(int'(W_CMP0) + k)) rdata_o = cmp[k];
    end
  end

  a_r8_irq_needs_enable: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ctrl.irq_en == '0) |-> !irq_o);
endmodule

// File: tb/sec_timekeeper_test.sv
`timescale 1ns/1ps
module sec_timekeeper_test;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        tick_i = 1'b0;
  logic [4:0]  addr_i = '0;
  logic        we_i = 1'b0;
  logic [31:0] wdata_i = '0;
  logic [31:0] rdata_o;
  logic        irq_o;
  logic        wake_o;

  sec_timekeeper uut (
    .clk_i(clk), .rst_ni(rst_ni), .tick_i(tick_i), .addr_i(addr_i),
    .we_i(we_i), .wdata_i(wdata_i), .rdata_o(rdata_o), .irq_o(irq_o), .wake_o(wake_o)
  );

  always #10 clk = ~clk;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  // reference state
  logic [31:0] m_up = 32'h0, m_dn = 32'hFFFF_FFFF, m_ctrl = 32'h0, m_key = 32'h0;
  logic [31:0] m_cmp0 = 32'h0, m_cmp1 = 32'h0;
  logic [2:0]  m_st = 3'b000;
  logic        s_irq, s_wake;
  localparam logic [31:0] KEYV = 32'hA5C3_5A3C;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] m_read(input logic [4:0] a);
    if (a[1:0] != 2'b00) return 32'h0;
    case (a[4:2])
      3'd0: return m_up;
      3'd1: return m_dn;
      3'd2: return m_cmp0;
      3'd3: return m_cmp1;
      3'd4: return m_ctrl;
      3'd5: return {29'h0, m_st};
      3'd6: return m_key;
      default: return 32'h0;
    endcase
  endfunction

  function automatic string tag_of(input logic [4:0] a);
    case (a[4:2])
      3'd0, 3'd1: return "R2 counter read";
      3'd2, 3'd3: return "R6 compare read";
      3'd4:       return "R11 control read";
      3'd5:       return "R7 status read";
      3'd6:       return "R10 key read";
      default:    return "R11 unmapped read";
    endcase
  endfunction

  // one clock cycle, entered and left at a falling edge
  task automatic step(input bit we, input logic [4:0] a, input logic [31:0] wd,
                      input bit tk, output logic [31:0] rd);
    logic [31:0] n_up, n_dn, n_ctrl, n_key, n_c0, n_c1;
    logic [2:0]  n_st, clr, setv;
    logic        w_up, w_dn, w_ok, wk;
    we_i = we; addr_i = a; wdata_i = wd; tick_i = tk;
    #2;
    rd = rdata_o; s_irq = irq_o; s_wake = wake_o;
    chk("R8 irq", 32'(irq_o), 32'(|(m_st[1:0] & m_ctrl[1:0])));
    wk = m_ctrl[7] | (m_st[0] & m_ctrl[2]) | (m_st[1] & m_ctrl[3]);
    chk("R9 wake", 32'(wake_o), 32'(wk));
    w_ok = we && a[1:0] == 2'b00;
    w_up = w_ok && a[4:2] == 3'd0;
    w_dn = w_ok && a[4:2] == 3'd1;
    n_up = m_up; n_dn = m_dn;
    if (m_ctrl[4]) begin n_up = 32'h0; n_dn = 32'hFFFF_FFFF; end
    else if (w_up || w_dn) begin
      if (w_up) n_up = wd;
      if (w_dn) n_dn = wd;
    end else if (tk && !m_ctrl[6]) begin n_up = m_up + 1; n_dn = m_dn - 1; end
    setv = {wk, m_up == m_cmp1, m_up == m_cmp0};
    clr  = (w_ok && a[4:2] == 3'd5) ? wd[2:0] : 3'b000;
    n_st = setv | (m_st & ~clr);
    n_ctrl = (w_ok && a[4:2] == 3'd4) ? (wd & 32'h0000_00DF) : m_ctrl;
    n_c0   = (w_ok && a[4:2] == 3'd2) ? wd : m_cmp0;
    n_c1   = (w_ok && a[4:2] == 3'd3) ? wd : m_cmp1;
    n_key  = (w_ok && a[4:2] == 3'd6) ? wd : m_key;
    @(posedge clk);
    m_up = n_up; m_dn = n_dn; m_st = n_st; m_ctrl = n_ctrl;
    m_cmp0 = n_c0; m_cmp1 = n_c1; m_key = n_key;
    @(negedge clk);
  endtask

  task automatic wr(input logic [4:0] a, input logic [31:0] d);
    logic [31:0] rd;
    step(1'b1, a, d, 1'b0, rd);
  endtask

  task automatic ticks(input int n);
    logic [31:0] rd;
    for (int i = 0; i < n; i++) step(1'b0, 5'h0, 32'h0, 1'b1, rd);
  endtask

  task automatic idle();
    logic [31:0] rd;
    step(1'b0, 5'h0, 32'h0, 1'b0, rd);
  endtask

  task automatic rd_lit(input logic [4:0] a, input logic [31:0] exp, input string tag);
    logic [31:0] rd;
    step(1'b0, a, 32'h0, 1'b0, rd);
    chk(tag, rd, exp);
  endtask

  task automatic rd_mod(input logic [4:0] a);
    logic [31:0] rd, exp;
    exp = m_read(a);
    step(1'b0, a, 32'h0, 1'b0, rd);
    chk(tag_of(a), rd, exp);
  endtask

  initial begin
    #(150000 * 20);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    logic [31:0] rd, d;
    void'($urandom(32'd2024));
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R1: values while held in reset
    addr_i = 5'h00; #1; chk("R1 up reset", rdata_o, 32'h0);
    addr_i = 5'h04; #1; chk("R1 down reset", rdata_o, 32'hFFFF_FFFF);
    addr_i = 5'h10; #1; chk("R1 ctrl reset", rdata_o, 32'h0);
    addr_i = 5'h18; #1; chk("R1 key reset", rdata_o, 32'h0);
    addr_i = 5'h14; #1; chk("R1 status reset", rdata_o, 32'h0);
    @(negedge clk);
    rst_ni = 1'b1;

    rd_lit(5'h14, 32'h0, "R1 status before first edge");
    rd_lit(5'h14, 32'h3, "R1 zero compares match at reset");
    rd_lit(5'h08, 32'h0, "R1 compare reset");

    wr(5'h18, KEYV);
    rd_lit(5'h18, KEYV, "R10 key readback");

    wr(5'h08, 32'hFFFF_FFFF); wr(5'h0C, 32'hFFFF_FFFF); wr(5'h14, 32'h7);
    rd_lit(5'h14, 32'h0, "R7 clear all");

    wr(5'h00, 32'd100); wr(5'h04, ~32'd100);
    rd_lit(5'h00, 32'd100, "R5 load up");
    rd_lit(5'h04, ~32'd100, "R5 load down");
    ticks(3);
    rd_lit(5'h00, 32'd103, "R2 up count");
    rd_lit(5'h04, ~32'd103, "R2 down count");

    wr(5'h00, 32'hFFFF_FFFF); wr(5'h04, 32'h0); ticks(1);
    rd_lit(5'h00, 32'h0, "R2 up wrap");
    rd_lit(5'h04, 32'hFFFF_FFFF, "R2 down wrap");

    // R5: load racing a tick
    step(1'b1, 5'h00, 32'd7, 1'b1, rd);
    rd_lit(5'h00, 32'd7, "R5 load beats tick");

    wr(5'h10, 32'h40); ticks(3);
    rd_lit(5'h00, 32'd7, "R3 held");
    wr(5'h00, 32'd50);
    rd_lit(5'h00, 32'd50, "R3 load while held");
    wr(5'h10, 32'h0); ticks(1);
    rd_lit(5'h00, 32'd51, "R3 resume");

    wr(5'h14, 32'h7);
    rd_lit(5'h14, 32'h0, "R7 clear");
    wr(5'h08, 32'd53); ticks(2); idle();
    rd_lit(5'h14, 32'h1, "R6 match sets flag");
    wr(5'h10, 32'h1); idle();
    chk("R8 irq enabled match", 32'(s_irq), 32'h1);
    wr(5'h14, 32'h1);
    rd_lit(5'h14, 32'h1, "R7 set wins over clear");
    wr(5'h08, 32'hFFFF_FFFF); wr(5'h14, 32'h1);
    rd_lit(5'h14, 32'h0, "R7 parked compare stays clear");
    chk("R8 irq drops", 32'(s_irq), 32'h0);

    wr(5'h0C, 32'd53); idle(); wr(5'h0C, 32'hFFFF_FFFF); wr(5'h14, 32'h1);
    rd_lit(5'h14, 32'h2, "R7 zero bits keep flag");
    wr(5'h14, 32'h2);
    rd_lit(5'h14, 32'h0, "R7 clear bit1");

    wr(5'h10, 32'h80); idle();
    chk("R9 forced wake", 32'(s_wake), 32'h1);
    rd_lit(5'h14, 32'h4, "R9 wake flag latched");
    wr(5'h10, 32'h0); wr(5'h14, 32'h4);
    rd_lit(5'h14, 32'h0, "R9 wake flag cleared");
    wr(5'h10, 32'h08); wr(5'h0C, 32'd53); idle(); idle();
    chk("R9 routed wake", 32'(s_wake), 32'h1);
    wr(5'h0C, 32'hFFFF_FFFF); wr(5'h10, 32'h0); wr(5'h14, 32'h7);

    wr(5'h10, 32'h10); ticks(2);
    rd_lit(5'h00, 32'h0, "R4 up pinned");
    rd_lit(5'h04, 32'hFFFF_FFFF, "R4 down pinned");
    rd_lit(5'h18, KEYV, "R4 key kept");
    wr(5'h10, 32'h0); ticks(1);
    rd_lit(5'h00, 32'h1, "R4 released");

    rd_lit(5'h1C, 32'h0, "R11 unmapped");
    rd_lit(5'h02, 32'h0, "R11 misaligned");
    wr(5'h10, 32'hFFFF_FFFF);
    rd_lit(5'h10, 32'hDF, "R11 ctrl bits");
    wr(5'h10, 32'h0); wr(5'h14, 32'h7);

    for (int it = 0; it < 3000; it++) begin
      case ($urandom % 10)
        0, 1, 2: ticks(1);
        3: begin
          d = $urandom & 32'h8F;
          if ($urandom % 4 == 0)  d |= 32'h40;
          if ($urandom % 10 == 0) d |= 32'h10;
          step(1'b1, 5'h10, d, 1'($urandom % 2), rd);
        end
        4: step(1'b1, ($urandom % 2) ? 5'h0C : 5'h08, m_up + ($urandom % 4), 1'($urandom % 2), rd);
        5: begin
          d = (($urandom % 2) ? m_cmp1 : m_cmp0) - ($urandom % 3);
          step(1'b1, 5'h00, d, 1'($urandom % 2), rd);
          step(1'b1, 5'h04, ~d, 1'($urandom % 2), rd);
        end
        6: step(1'b1, 5'h14, $urandom, 1'($urandom % 2), rd);
        7: step(1'b1, 5'h18, $urandom, 1'($urandom % 2), rd);
        default: rd_mod(($urandom % 16 == 0) ? 5'($urandom) : 5'(($urandom % 8) << 2));
      endcase
    end

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end
endmodule